// File: doc/BRIEF.md
# Configurable Logic Macrocell Register

This block is one programmable logic cell. It receives five product-term lines from an AND-array, an extra partial sum from the neighbouring cell, three global clocks, a global set/reset and a group of global output enables. A static configuration word decides what it does with them. It drives one function value, which goes both to the interconnect and to the pin, and one output-enable bit for the pin.

Each product term has a fixed control role that it takes whenever it is left out of the sum. Term 0 is the XOR operand, term 1 is the clock, term 2 is the set, term 3 is the reset and term 4 is the output enable. The terms that are in the sum are ORed together with the neighbour's sum when that input is enabled. The result is then XORed with a configurable operand. The register behind this stage can capture the value as a D flop, toggle on it as a T flop, or be bypassed. It takes its configured preload value at power-up and whenever the global set/reset is asserted.

The configuration word is static during operation. It is changed only while `rst_n` is low.

Top module: `logic_macrocell`

## Requirements
- R1: Configuration layout (default parameters):
  - bits [4:0]: sum mask; bit i puts product term i into the OR.
  - bit 5: share enable; it adds `share_in` to the OR.
  - bits [7:6]: XOR operand; 0 = constant 0, 1 = constant 1, 2 = term 0, 3 = constant 0.
  - bits [9:8]: register mode; 0 = bypass, 1 = D, 2 = T, 3 = bypass.
  - bits [11:10]: clock source; 0 to 2 select that global clock, 3 selects term 1.
  - bit 12: inverts the selected global clock.
  - bit 13: preload value.
  - bits [15:14]: output-enable source; 0 = off, 1 = on, 2 = term 4, 3 = global.
  - bit 16: inverts the global OE.
  - bit 17: index of the global OE.
  
  In bypass mode `cell_out` equals the OR of the masked terms and the enabled share input, XORed with the operand.
- R2: The XOR operand inverts the sum when it is constant 1, and follows term 0 when term 0 is selected and left out of the mask.
- R3: A product term whose mask bit is 1 goes only into the sum and has no effect as clock, set, reset or output enable.
- R4: In D mode `cell_out` takes the sum value on the active edge of the selected clock and does not change between edges.
- R5: In T mode the stored value inverts on an active edge when the sum is 1 and holds when the sum is 0.
- R6: Only the selected clock source produces captures. With source 3, a rising edge of term 1 is the clock.
- R7: With global-clock inversion set, capture happens on the falling edge of the selected global clock and not on its rising edge.
- R8: Term 2 (set) and term 3 (reset) act at once, without a clock. Reset wins when both are active, and an asserted set holds the value at 1 through clock edges.
- R9: While `rst_n` is low or `gsr` is high, the stored value equals the preload bit. Clock edges do not change it during that time, and it stays there after release until the next capture.
- R10: `pin_oe` is 0 for source off, 1 for source on, follows term 4 for the product-term source, and for the global source follows the indexed `goe` line, inverted when bit 16 is set.
- R11: In bypass mode, clock edges have no effect on `cell_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Power-up reset, active low; loads the preload value |
| gclk | input | 3 | Global clocks |
| gsr | input | 1 | Global set/reset, active high; loads the preload value |
| goe | input | 2 | Global output enables |
| pterm | input | 5 | Direct product terms |
| share_in | input | 1 | Partial sum from the neighbouring cell |
| cfg | input | 18 | Static configuration word |
| cell_out | output | 1 | Function value to the interconnect and the pin |
| pin_oe | output | 1 | Output enable for the pin |

## Verification
The hardest behaviour to reach is the interplay of the asynchronous controls with the clocked path. This covers a set or reset that arrives between clock edges, a set held across a capture edge, and both controls active at once. It also covers a term whose control role is switched off because it is routed into the sum. The bench reaches these states by driving each global clock by hand, so that any product term can change with no clock edge nearby. Before each scenario, the bench reconfigures the cell under a held reset with clock pulses, so that no stale capture leaks from one scenario into the next.

// File: rtl/mc_pkg.sv
`timescale 1ns/1ps
package mc_pkg;

  localparam int PT_N   = 5;
  localparam int PT_XOR = 0;
  localparam int PT_CLK = 1;
  localparam int PT_SET = 2;
  localparam int PT_RST = 3;
  localparam int PT_OE  = 4;

  typedef enum logic [1:0] {XS_ZERO = 2'd0, XS_ONE = 2'd1, XS_TERM = 2'd2, XS_SPARE = 2'd3} xor_src_e;
  typedef enum logic [1:0] {RM_BYPASS = 2'd0, RM_D = 2'd1, RM_T = 2'd2, RM_SPARE = 2'd3} reg_mode_e;
  typedef enum logic [1:0] {OE_OFF = 2'd0, OE_ON = 2'd1, OE_TERM = 2'd2, OE_GLOBAL = 2'd3} oe_src_e;

  // OR of the terms routed into the sum plus the optional neighbour sum
  function automatic logic f_or_stage(input logic [PT_N-1:0] terms,
                                      input logic [PT_N-1:0] mask,
                                      input logic share_en,
                                      input logic share_val);
    return (|(terms & mask)) | (share_en & share_val);
  endfunction

  function automatic logic f_xor_operand(input xor_src_e src, input logic term_ctrl);
    case (src)
      XS_ONE:  return 1'b1;
      XS_TERM: return term_ctrl;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic f_registered(input reg_mode_e mode);
    return (mode == RM_D) || (mode == RM_T);
  endfunction

  function automatic logic f_next_state(input reg_mode_e mode, input logic cur, input logic sum);
    case (mode)
      RM_D:    return sum;
      RM_T:    return cur ^ sum;
      default: return cur;
    endcase
  endfunction

endpackage

// File: rtl/mc_steer.sv
`timescale 1ns/1ps
module mc_steer import mc_pkg::*; (
  input  logic [PT_N-1:0] pterm,
  input  logic [PT_N-1:0] sum_mask,
  input  logic            share_en,
  input  logic            share_in,
  input  xor_src_e        xor_src,
  output logic            data_sum,
  output logic [PT_N-1:0] ctrl
);

  logic or_val;
  logic xor_op;

  // a term left out of the sum is free for its fixed control role
  for (genvar i = 0; i < PT_N; i++) begin : g_role
    assign ctrl[i] = pterm[i] & ~sum_mask[i];
  end

  assign or_val   = f_or_stage(pterm, sum_mask, share_en, share_in);
  assign xor_op   = f_xor_operand(xor_src, ctrl[PT_XOR]);
  assign data_sum = or_val ^ xor_op;

endmodule

// File: rtl/mc_clk.sv
`timescale 1ns/1ps
module mc_clk #(
  parameter int NUM_GCK = 3,
  localparam int CSW = $clog2(NUM_GCK + 1)
) (
  input  logic [NUM_GCK-1:0] gclk,
  input  logic [CSW-1:0]     clk_src,
  input  logic               clk_inv,
  input  logic               term_clk,
  output logic               reg_clk
);

  logic glb_pick;
  logic use_term;

  assign use_term = (int'(clk_src) >= NUM_GCK);

  always_comb begin
    glb_pick = 1'b0;
    for (int i = 0; i < NUM_GCK; i++) begin
      if (int'(clk_src) == i) glb_pick = gclk[i];
    end
  end

  assign reg_clk = use_term ? term_clk : (glb_pick ^ clk_inv);

endmodule

// File: rtl/mc_oe.sv
`timescale 1ns/1ps
module mc_oe import mc_pkg::*; #(
  parameter int NUM_GOE = 2,
  localparam int GOE_W = (NUM_GOE > 1) ? $clog2(NUM_GOE) : 1
) (
  input  oe_src_e            oe_src,
  input  logic [NUM_GOE-1:0] goe,
  input  logic [GOE_W-1:0]   goe_idx,
  input  logic               goe_inv,
  input  logic               term_oe,
  output logic               pin_oe
);

  logic [NUM_GOE-1:0] goe_pol;
  logic               glb_oe;

  for (genvar i = 0; i < NUM_GOE; i++) begin : g_pol
    assign goe_pol[i] = goe[i] ^ goe_inv;
  end

  always_comb begin
    glb_oe = 1'b0;
    for (int i = 0; i < NUM_GOE; i++) begin
      if (int'(goe_idx) == i) glb_oe = goe_pol[i];
    end
  end

  always_comb begin
    case (oe_src)
      OE_ON:     pin_oe = 1'b1;
      OE_TERM:   pin_oe = term_oe;
      OE_GLOBAL: pin_oe = glb_oe;
      default:   pin_oe = 1'b0;
    endcase
  end

endmodule

// File: rtl/mc_reg.sv
`timescale 1ns/1ps
module mc_reg import mc_pkg::*; (
  input  logic      reg_clk,
  input  logic      rst_n,
  input  logic      gsr,
  input  logic      term_set,
  input  logic      term_rst,
  input  logic      preload,
  input  reg_mode_e mode,
  input  logic      d,
  output logic      q
);

  logic init_load;
  logic async_busy;
  logic is_toggle;

  assign init_load  = ~rst_n | gsr;
  assign async_busy = init_load | term_set | term_rst;
  assign is_toggle  = (mode == RM_T);

  // priority: preload load, then reset, then set, then clocked update
  always_ff @(posedge reg_clk or posedge init_load or posedge term_rst or posedge term_set) begin
    if (init_load)     q <= preload;
    else if (term_rst) q <= 1'b0;
    else if (term_set) q <= 1'b1;
    else               q <= f_next_state(mode, q, d);
  end

  AST_GSR_PRELOAD: assert property (@(posedge reg_clk) disable iff (!rst_n)
    gsr |-> (q == preload)) else $error("gsr preload"); // R9

  AST_RESET_WINS: assert property (@(posedge reg_clk) disable iff (!rst_n)
    (!gsr && term_rst) |-> !q) else $error("reset priority"); // R8

  AST_SET_FORCES: assert property (@(posedge reg_clk) disable iff (!rst_n)
    (!gsr && term_set && !term_rst) |-> q) else $error("set hold"); // R8

  AST_TOGGLE_RULE: assert property (@(posedge reg_clk) disable iff (async_busy)
    is_toggle |=> (q == ($past(q) ^ $past(d)))) else $error("toggle rule"); // R5

endmodule

// File: rtl/logic_macrocell.sv
`timescale 1ns/1ps
module logic_macrocell import mc_pkg::*; #(
  parameter int NUM_GCK = 3,
  parameter int NUM_GOE = 2,
  localparam int CSW   = $clog2(NUM_GCK + 1),
  localparam int GOE_W = (NUM_GOE > 1) ? $clog2(NUM_GOE) : 1,
  localparam int CFG_W = 15 + CSW + GOE_W
) (
  input  logic               rst_n,
  input  logic [NUM_GCK-1:0] gclk,
  input  logic               gsr,
  input  logic [NUM_GOE-1:0] goe,
  input  logic [PT_N-1:0]    pterm,
  input  logic               share_in,
  input  logic [CFG_W-1:0]   cfg,
  output logic               cell_out,
  output logic               pin_oe
);

  localparam int OFS_MASK  = 0;
  localparam int OFS_SHARE = OFS_MASK + PT_N;
  localparam int OFS_XOR   = OFS_SHARE + 1;
  localparam int OFS_MODE  = OFS_XOR + 2;
  localparam int OFS_CSRC  = OFS_MODE + 2;
  localparam int OFS_CINV  = OFS_CSRC + CSW;
  localparam int OFS_PRE   = OFS_CINV + 1;
  localparam int OFS_OESRC = OFS_PRE + 1;
  localparam int OFS_GOINV = OFS_OESRC + 2;
  localparam int OFS_GOIDX = OFS_GOINV + 1;

  // decoded configuration fields
  logic [PT_N-1:0]  sum_mask;
  logic             share_en;
  xor_src_e         xor_src;
  reg_mode_e        mode;
  logic [CSW-1:0]   clk_src;
  logic             clk_inv;
  logic             preload;
  oe_src_e          oe_src;
  logic             goe_inv;
  logic [GOE_W-1:0] goe_idx;

  assign sum_mask = cfg[OFS_MASK +: PT_N];
  assign share_en = cfg[OFS_SHARE];
  assign xor_src  = xor_src_e'(cfg[OFS_XOR +: 2]);
  assign mode     = reg_mode_e'(cfg[OFS_MODE +: 2]);
  assign clk_src  = cfg[OFS_CSRC +: CSW];
  assign clk_inv  = cfg[OFS_CINV];
  assign preload  = cfg[OFS_PRE];
  assign oe_src   = oe_src_e'(cfg[OFS_OESRC +: 2]);
  assign goe_inv  = cfg[OFS_GOINV];
  assign goe_idx  = cfg[OFS_GOIDX +: GOE_W];

  // events between the sub-blocks
  logic            data_sum;
  logic [PT_N-1:0] ctrl;
  logic            reg_clk;
  logic            q;

  mc_steer u_steer (
    .pterm    (pterm),
    .sum_mask (sum_mask),
    .share_en (share_en),
    .share_in (share_in),
    .xor_src  (xor_src),
    .data_sum (data_sum),
    .ctrl     (ctrl)
  );

  mc_clk #(.NUM_GCK(NUM_GCK)) u_clk (
    .gclk     (gclk),
    .clk_src  (clk_src),
    .clk_inv  (clk_inv),
    .term_clk (ctrl[PT_CLK]),
    .reg_clk  (reg_clk)
  );

  mc_reg u_reg (
    .reg_clk  (reg_clk),
    .rst_n    (rst_n),
    .gsr      (gsr),
    .term_set (ctrl[PT_SET]),
    .term_rst (ctrl[PT_RST]),
    .preload  (preload),
    .mode     (mode),
    .d        (data_sum),
    .q        (q)
  );

  mc_oe #(.NUM_GOE(NUM_GOE)) u_oe (
    .oe_src  (oe_src),
    .goe     (goe),
    .goe_idx (goe_idx),
    .goe_inv (goe_inv),
    .term_oe (ctrl[PT_OE]),
    .pin_oe  (pin_oe)
  );

  assign cell_out = f_registered(mode) ? q : data_sum;

endmodule

// File: tb/logic_macrocell_bench.sv
`timescale 1ns/1ps
module logic_macrocell_bench;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [2:0]  gclk;
  logic        gsr;
  logic [1:0]  goe;
  logic [4:0]  pterm;
  logic        share_in;
  logic [17:0] cfg;
  logic        cell_out;
  logic        pin_oe;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  logic_macrocell u_logic_macrocell (
    .rst_n    (rst_n),
    .gclk     (gclk),
    .gsr      (gsr),
    .goe      (goe),
    .pterm    (pterm),
    .share_in (share_in),
    .cfg      (cfg),
    .cell_out (cell_out),
    .pin_oe   (pin_oe)
  );

  // layout written out per R1
  function automatic logic [17:0] mk(input logic [4:0] mask, input logic sh_en,
                                     input logic [1:0] xs, input logic [1:0] md,
                                     input logic [1:0] cs, input logic cinv,
                                     input logic pre, input logic [1:0] oes,
                                     input logic goinv, input logic goidx);
    return {goidx, goinv, oes, pre, cinv, cs, md, xs, sh_en, mask};
  endfunction

  function automatic logic ref_sum(input logic [4:0] p, input logic [4:0] mask,
                                   input logic sh_en, input logic sh, input logic [1:0] xs);
    logic acc;
    logic op;
    acc = 1'b0;
    for (int i = 0; i < 5; i++) if (mask[i] && p[i]) acc = 1'b1;
    if (sh_en && sh) acc = 1'b1;
    op = (xs == 2'd1) ? 1'b1 : ((xs == 2'd2) ? (p[0] & ~mask[0]) : 1'b0);
    return acc ^ op;
  endfunction

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
    end
  endtask

  task automatic power_up(input logic [17:0] c);
    rst_n = 1'b0; gsr = 1'b0; pterm = '0; share_in = 1'b0; goe = '0;
    #2 cfg = c;
    #2 gclk = 3'b111;
    #2 gclk = 3'b000;
    #2 rst_n = 1'b1;
    #2;
  endtask

  task automatic tick(input int i);
    gclk[i] = 1'b1; #3;
    gclk[i] = 1'b0; #3;
  endtask

  task automatic t_preload;
    power_up(mk(5'b00001, 0, 0, 1, 0, 0, 1, 0, 0, 0));
    chk("R9 preload 1 after power-up", cell_out, 1'b1);
    power_up(mk(5'b00001, 0, 0, 1, 0, 0, 0, 0, 0, 0));
    chk("R9 preload 0 after power-up", cell_out, 1'b0);
  endtask

  task automatic t_bypass;
    logic [4:0] m;
    m = 5'b10110;
    for (int xs = 0; xs < 3; xs++) begin
      power_up(mk(m, 1, xs[1:0], 0, 0, 0, 0, 0, 0, 0));
      for (int p = 0; p < 32; p += 7) begin
        for (int s = 0; s < 2; s++) begin
          pterm = p[4:0]; share_in = s[0]; #2;
          if (xs == 0) chk("R1 bypass sum", cell_out, ref_sum(p[4:0], m, 1, s[0], 2'd0));
          else chk("R2 xor operand", cell_out, ref_sum(p[4:0], m, 1, s[0], xs[1:0]));
        end
      end
    end
    power_up(mk(5'b00010, 0, 0, 0, 0, 0, 0, 0, 0, 0));
    pterm = 5'b00010; #2;
    tick(0);
    pterm = 5'b00000; #2;
    chk("R11 bypass follows input not clock", cell_out, 1'b0);
    tick(0);
    chk("R11 bypass after edge", cell_out, 1'b0);
  endtask

  task automatic t_dmode;
    power_up(mk(5'b00001, 1, 0, 1, 0, 0, 0, 0, 0, 0));
    pterm = 5'b00001; #2;
    chk("R4 no capture before edge", cell_out, 1'b0);
    tick(0);
    chk("R4 capture 1", cell_out, 1'b1);
    pterm = 5'b00000; #2;
    chk("R4 holds between edges", cell_out, 1'b1);
    tick(0);
    chk("R4 capture 0", cell_out, 1'b0);
    share_in = 1'b1; tick(0);
    chk("R4 capture share", cell_out, 1'b1);
  endtask

  task automatic t_tmode;
    power_up(mk(5'b00001, 0, 0, 2, 0, 0, 0, 0, 0, 0));
    pterm = 5'b00001; #2;
    tick(0); chk("R5 toggle to 1", cell_out, 1'b1);
    tick(0); chk("R5 toggle to 0", cell_out, 1'b0);
    tick(0); chk("R5 toggle to 1 again", cell_out, 1'b1);
    pterm = 5'b00000; #2;
    tick(0); chk("R5 hold with sum 0", cell_out, 1'b1);
    tick(0); chk("R5 hold second edge", cell_out, 1'b1);
  endtask

  task automatic t_clksel;
    power_up(mk(5'b00001, 0, 0, 1, 2, 0, 0, 0, 0, 0));
    pterm = 5'b00001; #2;
    tick(0); chk("R6 gclk0 not selected", cell_out, 1'b0);
    tick(1); chk("R6 gclk1 not selected", cell_out, 1'b0);
    tick(2); chk("R6 gclk2 selected", cell_out, 1'b1);
    power_up(mk(5'b00001, 0, 0, 1, 3, 0, 0, 0, 0, 0));
    pterm = 5'b00001; #2;
    tick(0); chk("R6 global ignored with term clock", cell_out, 1'b0);
    pterm = 5'b00011; #2;
    chk("R6 term clock rise captures", cell_out, 1'b1);
    pterm = 5'b00010; #2;
    chk("R6 no capture without term edge", cell_out, 1'b1);
    pterm = 5'b00000; #2;
    pterm = 5'b00010; #2;
    chk("R6 term clock captures 0", cell_out, 1'b0);
  endtask

  task automatic t_polarity;
    power_up(mk(5'b00001, 0, 0, 1, 0, 1, 0, 0, 0, 0));
    pterm = 5'b00001; #2;
    gclk[0] = 1'b1; #3;
    chk("R7 rising edge ignored when inverted", cell_out, 1'b0);
    gclk[0] = 1'b0; #3;
    chk("R7 falling edge captures when inverted", cell_out, 1'b1);
  endtask

  task automatic t_async;
    power_up(mk(5'b00001, 0, 0, 1, 0, 0, 0, 0, 0, 0));
    pterm = 5'b00100; #1;
    chk("R8 set acts without clock", cell_out, 1'b1);
    pterm = 5'b00000; #2;
    chk("R8 value kept after set release", cell_out, 1'b1);
    pterm = 5'b01000; #1;
    chk("R8 reset acts without clock", cell_out, 1'b0);
    pterm = 5'b01100; #2;
    chk("R8 reset wins over set", cell_out, 1'b0);
    pterm = 5'b00000; #2;
    pterm = 5'b00100; #2;
    pterm = 5'b01100; #1;
    chk("R8 reset wins while set held", cell_out, 1'b0);
    pterm = 5'b00000; #2;
    pterm = 5'b00100; #2;
    tick(0);
    chk("R8 set held across edge", cell_out, 1'b1);
    pterm = 5'b00000; #2;
    // R3: set term routed into sum loses its control role
    power_up(mk(5'b00101, 0, 0, 1, 0, 0, 0, 0, 0, 0));
    pterm = 5'b00100; #2;
    chk("R3 summed term does not set", cell_out, 1'b0);
    tick(0);
    chk("R3 summed term feeds data", cell_out, 1'b1);
  endtask

  task automatic t_gsr;
    power_up(mk(5'b00001, 0, 0, 1, 0, 0, 1, 0, 0, 0));
    tick(0); chk("R9 capture 0 over preload", cell_out, 1'b0);
    gsr = 1'b1; #2;
    chk("R9 gsr loads preload 1", cell_out, 1'b1);
    tick(0); chk("R9 edge ignored under gsr", cell_out, 1'b1);
    gsr = 1'b0; #2;
    chk("R9 preload kept after gsr release", cell_out, 1'b1);
    tick(0); chk("R9 capture after gsr", cell_out, 1'b0);
    power_up(mk(5'b00001, 0, 0, 1, 0, 0, 0, 0, 0, 0));
    pterm = 5'b00001; #2;
    tick(0); chk("R9 capture 1 before gsr", cell_out, 1'b1);
    gsr = 1'b1; #2;
    chk("R9 gsr loads preload 0", cell_out, 1'b0);
    gsr = 1'b0; #2;
  endtask

  task automatic t_oe;
    power_up(mk(5'b00000, 0, 0, 0, 0, 0, 0, 0, 0, 0));
    chk("R10 oe off", pin_oe, 1'b0);
    power_up(mk(5'b00000, 0, 0, 0, 0, 0, 0, 1, 0, 0));
    chk("R10 oe on", pin_oe, 1'b1);
    power_up(mk(5'b00000, 0, 0, 0, 0, 0, 0, 2, 0, 0));
    pterm = 5'b10000; #2;
    chk("R10 oe from term 4 high", pin_oe, 1'b1);
    pterm = 5'b00000; #2;
    chk("R10 oe from term 4 low", pin_oe, 1'b0);
    power_up(mk(5'b10000, 0, 0, 0, 0, 0, 0, 2, 0, 0));
    pterm = 5'b10000; #2;
    chk("R3 summed term does not enable", pin_oe, 1'b0);
    power_up(mk(5'b00000, 0, 0, 0, 0, 0, 0, 3, 1, 1));
    chk("R10 global 1 inverted idle", pin_oe, 1'b1);
    goe = 2'b10; #2;
    chk("R10 global 1 inverted high", pin_oe, 1'b0);
    goe = 2'b01; #2;
    chk("R10 other global ignored", pin_oe, 1'b1);
    power_up(mk(5'b00000, 0, 0, 0, 0, 0, 0, 3, 0, 0));
    goe = 2'b01; #2;
    chk("R10 global 0 true", pin_oe, 1'b1);
    goe = 2'b10; #2;
    chk("R10 global 0 low", pin_oe, 1'b0);
  endtask

  initial begin
    rst_n = 1'b0; gclk = '0; gsr = 1'b0; goe = '0; pterm = '0; share_in = 1'b0; cfg = '0;
    #1;
    chk("R9 output under reset", cell_out, 1'b0);
    t_preload();
    t_bypass();
    t_dmode();
    t_tmode();
    t_clksel();
    t_polarity();
    t_async();
    t_gsr();
    t_oe();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (!done && cycles > 20000) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 20000);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule